// File: doc/BRIEF.md
# DDR2 Burst Latency Sequencer

This block sits on the controller side of a DDR2 interface. It turns accepted column requests into READ or WRITE command codes on the command pins and the column address bus. It then places the data phase that belongs to each command in time. The placement follows a programmable CAS latency and a programmable additive latency. For reads it raises a capture window during the beats the memory returns. For writes it produces the strobe output enable, the strobe level, and the data output enables, including a half-clock preamble before the burst and a half-clock postamble after it.

Every data-side output is a two-bit vector. Each bit covers one half-clock slot of the current clock: slot 0 is the half that follows the rising edge, and slot 1 is the half before the next rising edge. The I/O cells serialise these vectors at twice the clock rate, so events that fall on a half clock can be expressed without a second clock.

A requester offers one command at a time on a valid/ready handshake. The block holds off a request if it would collide with a data phase already scheduled. It also holds off a request while the activate-to-column delay is still running after an ACTIVE reported on `act_i`. The latencies in force when a command is accepted stay attached to that command, even if the configuration inputs change later.

Top module: `ddr2_burst_seq`

## Requirements
- R1: While reset is asserted, all four command pins are high (deselect) and every data-side output is zero. The first clock after reset shows NOP, with `req_ready` high when no ACTIVE is reported.
- R2: An accepted read drives {cs_n,ras_n,cas_n,we_n} = 0,1,0,1 for exactly one clock. An accepted write drives 0,1,0,0. In both cases the column sits on `cmd_col` during that clock, which is the clock after acceptance. Every other clock out of reset is NOP (0,1,1,1) with `cmd_col` zero.
- R3: Take the clock in which a READ is on the pins as clock 0, and let RL = AL + CL. `rd_cap` is 2'b11 in clocks RL and RL+1 and zero otherwise.
- R4: For a WRITE, with WL = AL + CL − 1 and CL of at least 2, `dq_oe` is 2'b11 in clocks WL and WL+1 and zero otherwise.
- R5: During clocks WL and WL+1 of a write, `dqs_out` is 2'b01. The strobe is high in slot 0 and low in slot 1, so the first beat lines up with a rising strobe edge. `dqs_out` is zero at every other time.
- R6: The write preamble drives the strobe low in slot 1 of clock WL−1: `dqs_oe` = 2'b10 and `dqs_out` = 0 in that clock.
- R7: After the last beat, the strobe is held low for slot 0 of clock WL+2 (`dqs_oe` = 2'b01) and then released. `dqs_oe` is 2'b11 in clocks WL and WL+1 and zero outside clocks WL−1 to WL+2.
- R8: When `act_i` is high in clock a, `req_ready` is low in clock a and stays low until clock a+TRCD−1. The earliest column command therefore reaches the pins in clock a+TRCD.
- R9: A command occupies clocks [RL, RL+1] if it is a read and [RL−2, RL+1] if it is a write. Offsets are counted from its own command clock. `req_ready` is high exactly when the new command's span would not overlap any span still pending (and R8 allows issue).
- R10: Changing `cfg_cl` or `cfg_al` after a command is accepted does not move that command's data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | LAT_W | CAS latency in clocks (at least 2) |
| cfg_al | input | LAT_W | Additive latency in clocks |
| act_i | input | 1 | High in the clock an ACTIVE is on the pins |
| req_valid | input | 1 | A column request is offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_col | input | COL_W | Starting column of the burst |
| req_ready | output | 1 | The offered request is accepted at this edge |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_col | output | COL_W | Column address on the command clock |
| rd_cap | output | 2 | Read capture window per half-clock slot |
| dqs_oe | output | 2 | Write strobe output enable per slot |
| dqs_out | output | 2 | Write strobe level per slot |
| dq_oe | output | 2 | Write data output enable per slot |

## Verification
The command code appears one clock after the accepting edge. The read window is due RL = AL+CL clocks after that command clock. The write enables are due one clock earlier, with the preamble one clock before them and the postamble two clocks after them. The bench accepts at a rising edge and treats the next falling edge as clock 0. It then samples every output at each falling edge up to RL+4 and compares it with these offsets, sweeping CL 2 to 5 and AL 0 to 3 for both directions. The handshake checks predict the first ready clock of a second request as the end of the first span minus the start of the second span. The activate check predicts TRCD−1 clocks of stall.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t PINS_READ  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
   localparam cmd_pins_t PINS_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/ddr2_seq_gate.sv
// Issue gate: activate-to-column countdown plus a per-clock bus occupancy map.
module ddr2_seq_gate #(
   parameter int LAT_W = 3,
   parameter int TRCD  = 3,
   parameter int OCC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             req_valid_i,
   input  logic             req_write_i,
   input  logic [LAT_W+1:0] rl_i,
   output logic             ready_o,
   output logic             accept_o
);

   localparam int CNT_W = $clog2(TRCD + 1);

   logic [CNT_W-1:0] rcd_cnt;
   logic [OCC_W-1:0] occ;
   logic [OCC_W-1:0] occ_next;
   logic [OCC_W-1:0] span;
   logic [LAT_W+1:0] span_lo;
   logic [LAT_W+1:0] span_hi;
   logic             clash;

   // A read holds the bus for its two data clocks; a write also covers its
   // preamble and postamble clocks, so both spans end at RL+1.
   assign span_lo = req_write_i ? (rl_i - (LAT_W+2)'(2)) : rl_i;
   assign span_hi = rl_i + (LAT_W+2)'(1);

   always_comb begin
      for (int j = 0; j < OCC_W; j++) begin
         span[j] = ((LAT_W+2)'(j) >= span_lo) && ((LAT_W+2)'(j) <= span_hi);
      end
   end

   assign occ_next = occ >> 1;
   assign clash    = |(occ_next & span);
   assign ready_o  = !act_i && (rcd_cnt == '0) && !clash;
   assign accept_o = req_valid_i && ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcd_cnt <= '0;
         occ     <= '0;
      end else begin
         if (act_i) begin
            rcd_cnt <= CNT_W'(TRCD - 2);
         end else if (rcd_cnt != '0) begin
            rcd_cnt <= rcd_cnt - 1'b1;
         end
         occ <= occ_next | (accept_o ? span : '0);
      end
   end

   // R4: the latency arithmetic assumes CAS latency of at least two.
   p_cl_floor_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |-> (rl_i >= (LAT_W+2)'(2)));

   // R8: no command leaves while the activate delay is still counting.
   p_rcd_wait_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rcd_cnt != '0) |-> !accept_o);

endmodule

// File: rtl/ddr2_seq_wrphase.sv
// Write data phase: one mark per pending write walks down to the WL clock.
module ddr2_seq_wrphase #(
   parameter int LAT_W = 3,
   parameter int MW    = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LAT_W+1:0] wl_i,
   output logic [1:0]       dqs_oe_o,
   output logic [1:0]       dqs_out_o,
   output logic [1:0]       dq_oe_o
);

   logic [MW-1:0] mark;
   logic [1:0]    tail;
   logic          pre_clk;
   logic          beat_a;
   logic          beat_b;
   logic          post_clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark <= '0;
         tail <= '0;
      end else begin
         mark <= (mark >> 1) | (start_i ? (MW'(1) << wl_i) : '0);
         tail <= {tail[0], mark[0]};
      end
   end

   assign pre_clk  = mark[1];
   assign beat_a   = mark[0];
   assign beat_b   = tail[0];
   assign post_clk = tail[1];

   for (genvar s = 0; s < 2; s++) begin : g_slot
      if (s == 0) begin : g_first_half
         assign dqs_oe_o[s]  = beat_a | beat_b | post_clk;
         assign dqs_out_o[s] = beat_a | beat_b;
      end else begin : g_second_half
         assign dqs_oe_o[s]  = pre_clk | beat_a | beat_b;
         assign dqs_out_o[s] = 1'b0;
      end
      assign dq_oe_o[s] = beat_a | beat_b;
   end

   // R6: data never starts without the preamble half clock before it.
   p_preamble_lead_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe_o[0]) |-> $past(dqs_oe_o[1]) && !$past(dqs_oe_o[0]));

   // R7: the clock after the last beat keeps only the low postamble half.
   p_postamble_tail_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe_o[1]) |-> (dqs_oe_o == 2'b01) && (dqs_out_o == 2'b00));

endmodule

// File: rtl/ddr2_seq_rdphase.sv
// Read capture window: two clocks from the RL point.
module ddr2_seq_rdphase #(
   parameter int LAT_W = 3,
   parameter int MW    = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LAT_W+1:0] rl_i,
   output logic [1:0]       cap_o
);

   logic [MW-1:0] mark;
   logic          tail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark <= '0;
         tail <= 1'b0;
      end else begin
         mark <= (mark >> 1) | (start_i ? (MW'(1) << rl_i) : '0);
         tail <= mark[0];
      end
   end

   for (genvar s = 0; s < 2; s++) begin : g_slot
      assign cap_o[s] = mark[0] | tail;
   end

   // R3: every window lasts exactly two clocks.
   p_window_pair_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_o[0]) |=> cap_o[0]);

endmodule

// File: rtl/ddr2_burst_seq.sv
module ddr2_burst_seq
   import ddr2_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int LAT_W = 3,
   parameter int TRCD  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] cfg_cl,
   input  logic [LAT_W-1:0] cfg_al,
   input  logic             act_i,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [COL_W-1:0] req_col,
   output logic             req_ready,
   output logic             cmd_cs_n,
   output logic             cmd_ras_n,
   output logic             cmd_cas_n,
   output logic             cmd_we_n,
   output logic [COL_W-1:0] cmd_col,
   output logic [1:0]       rd_cap,
   output logic [1:0]       dqs_oe,
   output logic [1:0]       dqs_out,
   output logic [1:0]       dq_oe
);

   localparam int RL_MAX = 2 * ((1 << LAT_W) - 1);
   localparam int MARK_W = RL_MAX + 1;
   localparam int OCC_W  = RL_MAX + 2;

   if (LAT_W < 2) begin : g_bad_lat
      $error("LAT_W must allow a CAS latency of at least 2");
   end
   if (TRCD < 2) begin : g_bad_trcd
      $error("TRCD must be at least 2 clocks");
   end
   if (COL_W < 1) begin : g_bad_col
      $error("COL_W must be positive");
   end

   logic [LAT_W+1:0] rl;
   logic [LAT_W+1:0] wl;
   logic             accept;
   cmd_pins_t        pins;

   assign rl = {2'b00, cfg_cl} + {2'b00, cfg_al};
   assign wl = rl - (LAT_W+2)'(1);

   ddr2_seq_gate #(
      .LAT_W (LAT_W),
      .TRCD  (TRCD),
      .OCC_W (OCC_W)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act_i),
      .req_valid_i (req_valid),
      .req_write_i (req_write),
      .rl_i        (rl),
      .ready_o     (req_ready),
      .accept_o    (accept)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins    <= PINS_DESEL;
         cmd_col <= '0;
      end else if (accept) begin
         pins    <= req_write ? PINS_WRITE : PINS_READ;
         cmd_col <= req_col;
      end else begin
         pins    <= PINS_NOP;
         cmd_col <= '0;
      end
   end

   assign cmd_cs_n  = pins.cs_n;
   assign cmd_ras_n = pins.ras_n;
   assign cmd_cas_n = pins.cas_n;
   assign cmd_we_n  = pins.we_n;

   ddr2_seq_rdphase #(
      .LAT_W (LAT_W),
      .MW    (MARK_W)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept && !req_write),
      .rl_i    (rl),
      .cap_o   (rd_cap)
   );

   ddr2_seq_wrphase #(
      .LAT_W (LAT_W),
      .MW    (MARK_W)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (accept && req_write),
      .wl_i      (wl),
      .dqs_oe_o  (dqs_oe),
      .dqs_out_o (dqs_out),
      .dq_oe_o   (dq_oe)
   );

   // R2: an accepted request is on the pins at the next clock.
   p_accept_issues_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!cmd_cs_n && cmd_ras_n && !cmd_cas_n
                                    && (cmd_we_n == !$past(req_write))));

   // R2: no handshake, no column command.
   p_quiet_nop_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> (cmd_cas_n && cmd_ras_n && !cmd_cs_n));

   // R8: an ACTIVE in this clock blocks column issue.
   p_act_blocks_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> !req_ready);

   // R9: the read window and the driven write strobe never share a clock.
   p_bus_exclusive_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !((|rd_cap) && (|dqs_oe)));

endmodule

// File: tb/ddr2_burst_seq_tb.sv
`timescale 1ns/1ps
module ddr2_burst_seq_tb;

   localparam int COL_W = 10;
   localparam int LAT_W = 3;
   localparam int TRCD  = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [LAT_W-1:0] cfg_cl;
   logic [LAT_W-1:0] cfg_al;
   logic             act_i;
   logic             req_valid;
   logic             req_write;
   logic [COL_W-1:0] req_col;
   logic             req_ready;
   logic             cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [COL_W-1:0] cmd_col;
   logic [1:0]       rd_cap, dqs_oe, dqs_out, dq_oe;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   ddr2_burst_seq #(.COL_W(COL_W), .LAT_W(LAT_W), .TRCD(TRCD)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
      .act_i(act_i), .req_valid(req_valid), .req_write(req_write),
      .req_col(req_col), .req_ready(req_ready),
      .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
      .cmd_we_n(cmd_we_n), .cmd_col(cmd_col), .rd_cap(rd_cap),
      .dqs_oe(dqs_oe), .dqs_out(dqs_out), .dq_oe(dq_oe)
   );

   task automatic check(input string tag, input int got, input int want);
      n_cmp++;
      if (got != want) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, want, $time);
      end
   endtask

   function automatic int pins4();
      return {28'd0, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
   endfunction

   // one read or write, every output compared over its full window
   task automatic run_single(input int cl, input int al, input bit wr, input int col);
      int rl = cl + al;
      int wl = rl - 1;
      int e_cap, e_dq, e_dqs, e_oe;
      @(negedge clk);
      cfg_cl = LAT_W'(cl); cfg_al = LAT_W'(al);
      req_valid = 1'b1; req_write = wr; req_col = COL_W'(col);
      #1 check("R9 idle ready", int'(req_ready), 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_cl = '1; cfg_al = '1;   // R10: late change must not move this burst
      #1;
      check("R2 command code", pins4(), wr ? 4'b0100 : 4'b0101);
      check("R2 column", int'(cmd_col), col);
      for (int k = 0; k <= rl + 4; k++) begin
         if (k > 0) begin
            @(negedge clk);
            #1;
            check("R2 nop", pins4(), 4'b0111);
         end
         e_cap = (!wr && (k == rl || k == rl + 1)) ? 3 : 0;
         e_dq  = (wr && (k == wl || k == wl + 1)) ? 3 : 0;
         e_dqs = (wr && (k == wl || k == wl + 1)) ? 1 : 0;
         e_oe  = !wr ? 0 : (k == wl - 1) ? 2 : (k == wl || k == wl + 1) ? 3 :
                 (k == wl + 2) ? 1 : 0;
         check("R3 R10 read window", int'(rd_cap), e_cap);
         check("R4 R10 dq enable", int'(dq_oe), e_dq);
         check("R5 strobe level", int'(dqs_out), e_dqs);
         check("R6 R7 strobe enable", int'(dqs_oe), e_oe);
      end
   endtask

   // second request held while the first is pending; first ready clock predicted
   task automatic run_pair(input bit t1, input bit t2, input int cl, input int al);
      int rl = cl + al;
      int e1 = rl + 1;
      int s2 = t2 ? rl - 2 : rl;
      int want = (e1 - s2 > 0) ? e1 - s2 : 0;
      int first = -1;
      @(negedge clk);
      cfg_cl = LAT_W'(cl); cfg_al = LAT_W'(al);
      req_valid = 1'b1; req_write = t1; req_col = COL_W'(5);
      @(posedge clk);
      @(negedge clk);
      req_write = t2; req_col = COL_W'(9);
      for (int c = 0; c < 12 && first < 0; c++) begin
         #1;
         if (req_ready) first = c;
         else @(negedge clk);
      end
      check("R9 first ready clock", first, want);
      if (first >= 0) begin
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         #1 check("R9 R2 second command", pins4(), t2 ? 4'b0100 : 4'b0101);
      end
      req_valid = 1'b0;
      repeat (rl + 6) @(negedge clk);
   endtask

   task automatic run_rcd(input bit wr);
      int c = 1;
      @(negedge clk);
      cfg_cl = 3'd3; cfg_al = 3'd0;
      act_i = 1'b1; req_valid = 1'b1; req_write = wr; req_col = COL_W'(77);
      #1 check("R8 blocked with ACTIVE", int'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
      act_i = 1'b0;
      while (c < 10) begin
         #1;
         if (req_ready) break;
         @(negedge clk);
         c++;
      end
      check("R8 stall clocks", c, TRCD - 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1 check("R8 command clock", pins4(), wr ? 4'b0100 : 4'b0101);
      repeat (10) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; act_i = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_col = '0; cfg_cl = 3'd3; cfg_al = 3'd0;
      repeat (3) @(negedge clk);
      check("R1 reset pins", pins4(), 4'b1111);
      check("R1 reset data side", int'({rd_cap, dqs_oe, dqs_out, dq_oe}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 nop after reset", pins4(), 4'b0111);
      check("R1 ready after reset", int'(req_ready), 1);

      for (int cl = 2; cl <= 5; cl++)
         for (int al = 0; al <= 3; al++)
            for (int wr = 0; wr < 2; wr++)
               run_single(cl, al, wr[0], cl * 37 + al * 5 + wr);

      for (int t = 0; t < 4; t++) begin
         run_pair(t[1], t[0], 2, 0);
         run_pair(t[1], t[0], 3, 2);
      end

      run_rcd(1'b0);
      run_rcd(1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule